// File: doc/BRIEF.md
# Pin Change Interrupt Controller

This block watches a bank of digital input pins and raises a sticky interrupt flag whenever any pin that software has enabled changes level, on either a rising or a falling edge. Each input passes through a synchronizer. The synchronized value is compared against a stored reference snapshot. Any difference on an enabled pin sets the flag. When software acknowledges the flag, the reference is reloaded from the current synchronized inputs, so the next change is measured from that point.

The per-pin interrupt enables and the per-pin weak pull-up enables each occupy two 16-bit register words. A pin that is driven as an output never gets its pull-up, whatever its enable bit holds. A separate wake request is built without any clock from the raw pins and the reference. It therefore rises while the system clock is stopped, and it can restart the clock. Once the clock runs again, the same change passes through the synchronizer and sets the interrupt flag.

Top module: `pinChangeNotifier`

## Requirements
- R1: After reset, irqFlag, wakeReq and every pullEn bit are 0, and all enables, pull-up enables and the reference are 0.
- R2: A rising level on an enabled pin sets irqFlag at the third rising clock edge after the pin changes (two synchronizer stages plus the flag register).
- R3: A falling level on an enabled pin, measured against the reference, sets irqFlag with the same latency as R2.
- R4: A change on a pin whose enable bit is 0 never sets irqFlag and never raises wakeReq.
- R5: irqFlag stays 1 until flagClr is pulsed, even if the pin returns to its reference level. A flagClr pulse (write-one-to-clear) loads the reference from the synchronized inputs.
- R6: When flagClr and a fresh mismatch occur at the same edge, the clear wins: irqFlag is 0 afterwards, and the mismatch is absorbed into the new reference.
- R7: wakeReq is high, with no clock running, whenever an enabled raw input differs from the reference.
- R8: A change that occurs while the clock is stopped sets irqFlag at the third rising edge after the clock resumes.
- R9: With wrEn high at a rising edge, wrSel selects the word that wrData is written to. 0 writes the enables of pins 0-15 from bits 15:0. 1 writes the enables of pins 16-30 from bits 14:0, and bit 15 is ignored. 2 and 3 write the pull-up enables with the same layout.
- R10: pullEn[i] is 1 only when the pull-up enable of pin i is 1 and pinDir[i] is 0. pinDir 1 means the pin is an output.
- R11: Several enabled pins that change at the same time produce one flag, and a single flagClr clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; may be stopped |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | 31 | Raw input pin levels |
| pinDir | input | 31 | Pin direction, 1 = output |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Register word select |
| wrData | input | 16 | Register write data |
| flagClr | input | 1 | Write-one-to-clear pulse for the flag |
| pullEn | output | 31 | Effective pull-up enable per pin |
| irqFlag | output | 1 | Sticky change interrupt flag |
| wakeReq | output | 1 | Clockless change request for wake-up |

## Verification
The assertions assume that flagClr and wrEn are single-cycle pulses sampled at clock edges, and that rstN is released while the clock is low. The stimulus changes every input only at falling edges. It stops the clock only while the clock is low, and it holds the pins steady for several edges around each check of an expected flag. The flag-latency property assumes the raw pins may change at any time, so it ties a rising flag only to the synchronized mismatch seen one edge earlier.

// File: rtl/pinChangePkg.sv
package pinChangePkg;

  typedef enum logic [1:0] {
    SEL_EN_LO = 2'd0,
    SEL_EN_HI = 2'd1,
    SEL_PU_LO = 2'd2,
    SEL_PU_HI = 2'd3
  } regSel_e;

  typedef struct packed {
    logic wrEnLo;
    logic wrEnHi;
    logic wrPuLo;
    logic wrPuHi;
    logic refLoad;
  } strobes_t;

endpackage

// File: rtl/pinChangeCtrl.sv
module pinChangeCtrl
  import pinChangePkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [1:0] wrSel,
  input  logic       flagClr,
  input  logic       mismatchAny,
  output strobes_t   strobes,
  output logic       irqFlag
);

  regSel_e selDec;

  always_comb begin
    selDec          = regSel_e'(wrSel);
    strobes         = '0;
    strobes.wrEnLo  = wrEn && (selDec == SEL_EN_LO);
    strobes.wrEnHi  = wrEn && (selDec == SEL_EN_HI);
    strobes.wrPuLo  = wrEn && (selDec == SEL_PU_LO);
    strobes.wrPuHi  = wrEn && (selDec == SEL_PU_HI);
    strobes.refLoad = flagClr;
  end

  // Clear has priority over a mismatch seen at the same edge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        irqFlag <= 1'b0;
    else if (flagClr) irqFlag <= 1'b0;
    else if (mismatchAny) irqFlag <= 1'b1;
  end

  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    flagClr |=> !irqFlag); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlag && !flagClr) |=> irqFlag); // R5
  AST_SET_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqFlag) |-> $past(mismatchAny)); // R2
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rstN)
    (!irqFlag && !mismatchAny) |=> !irqFlag); // R4

endmodule

// File: rtl/pinChangeDatapath.sv
module pinChangeDatapath
  import pinChangePkg::*;
#(
  parameter int NUM_PINS    = 31,
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic [NUM_PINS-1:0] pinDir,
  input  logic [WORD_W-1:0]   wrData,
  input  strobes_t            strobes,
  output logic [NUM_PINS-1:0] pullEn,
  output logic                mismatchAny,
  output logic                wakeReq
);

  localparam int HI_W = NUM_PINS - WORD_W;

  logic [SYNC_STAGES-1:0][NUM_PINS-1:0] syncChain;
  logic [NUM_PINS-1:0] syncedPins;
  logic [NUM_PINS-1:0] enMask;
  logic [NUM_PINS-1:0] puMask;
  logic [NUM_PINS-1:0] refState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncChain <= '0;
    else       syncChain <= {syncChain[SYNC_STAGES-2:0], pinIn};
  end

  assign syncedPins = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enMask <= '0;
      puMask <= '0;
    end else begin
      if (strobes.wrEnLo) enMask[WORD_W-1:0]        <= wrData;
      if (strobes.wrEnHi) enMask[NUM_PINS-1:WORD_W] <= wrData[HI_W-1:0];
      if (strobes.wrPuLo) puMask[WORD_W-1:0]        <= wrData;
      if (strobes.wrPuHi) puMask[NUM_PINS-1:WORD_W] <= wrData[HI_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                refState <= '0;
    else if (strobes.refLoad) refState <= syncedPins;
  end

  assign mismatchAny = |(enMask & (syncedPins ^ refState));
  // Clockless path: raw pins against the reference, usable as a wake-up.
  assign wakeReq     = |(enMask & (pinIn ^ refState));
  assign pullEn      = puMask & ~pinDir;

  AST_REF_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobes.refLoad |=> (refState == $past(syncedPins))); // R5
  AST_WRITE_LO: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrEnLo |=> (enMask[WORD_W-1:0] == $past(wrData))); // R9
  AST_PU_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.wrPuLo && !strobes.wrPuHi) |=> $stable(puMask)); // R9

endmodule

// File: rtl/pinChangeNotifier.sv
module pinChangeNotifier
  import pinChangePkg::*;
#(
  parameter int NUM_PINS    = 31,
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic [NUM_PINS-1:0] pinDir,
  input  logic                wrEn,
  input  logic [1:0]          wrSel,
  input  logic [WORD_W-1:0]   wrData,
  input  logic                flagClr,
  output logic [NUM_PINS-1:0] pullEn,
  output logic                irqFlag,
  output logic                wakeReq
);

  strobes_t strobes;
  logic     mismatchAny;

  pinChangeCtrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .wrEn        (wrEn),
    .wrSel       (wrSel),
    .flagClr     (flagClr),
    .mismatchAny (mismatchAny),
    .strobes     (strobes),
    .irqFlag     (irqFlag)
  );

  pinChangeDatapath #(
    .NUM_PINS    (NUM_PINS),
    .WORD_W      (WORD_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .pinIn       (pinIn),
    .pinDir      (pinDir),
    .wrData      (wrData),
    .strobes     (strobes),
    .pullEn      (pullEn),
    .mismatchAny (mismatchAny),
    .wakeReq     (wakeReq)
  );

endmodule

// File: tb/pinChangeNotifier_bench.sv
module pinChangeNotifier_bench;

  localparam int NP = 31;
  localparam int WW = 16;
  localparam int NS = 2;

  logic          clk = 1'b0;
  logic          clkRun = 1'b1;
  logic          rstN = 1'b0;
  logic [NP-1:0] pinIn = '0;
  logic [NP-1:0] pinDir = '0;
  logic          wrEn = 1'b0;
  logic [1:0]    wrSel = 2'd0;
  logic [WW-1:0] wrData = '0;
  logic          flagClr = 1'b0;
  logic [NP-1:0] pullEn;
  logic          irqFlag;
  logic          wakeReq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Behavioural reference model
  logic [NP-1:0] history[$];
  logic [NP-1:0] mEn = '0, mPu = '0, mRef = '0;
  bit            mFlag = 1'b0;

  pinChangeNotifier u_pinChangeNotifier (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .pinDir(pinDir),
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData), .flagClr(flagClr),
    .pullEn(pullEn), .irqFlag(irqFlag), .wakeReq(wakeReq)
  );

  always begin
    #2;
    if (clkRun) clk = ~clk;
  end

  task automatic check(input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [NP-1:0] expWake();
    return {{(NP-1){1'b0}}, |(mEn & (pinIn ^ mRef))};
  endfunction

  always @(posedge clk) begin
    logic [NP-1:0] seen;
    bit mism;
    if (!rstN) begin
      history.delete();
      mEn = '0; mPu = '0; mRef = '0; mFlag = 1'b0;
    end else begin
      seen = (history.size() >= NS) ? history[history.size()-NS] : '0;
      mism = |(mEn & (seen ^ mRef));
      if (flagClr) begin
        mFlag = 1'b0;
        mRef  = seen;
      end else if (mism) mFlag = 1'b1;
      if (wrEn) begin
        case (wrSel)
          2'd0: mEn[15:0]  = wrData;
          2'd1: mEn[30:16] = wrData[14:0];
          2'd2: mPu[15:0]  = wrData;
          default: mPu[30:16] = wrData[14:0];
        endcase
      end
      history.push_back(pinIn);
      if (history.size() > 8) void'(history.pop_front());
    end
    #1;
    if (rstN) begin
      check("R5 model irqFlag", {{(NP-1){1'b0}}, irqFlag}, {{(NP-1){1'b0}}, mFlag});
      check("R7 model wakeReq", {{(NP-1){1'b0}}, wakeReq}, expWake());
      check("R10 model pullEn", pullEn, mPu & ~pinDir);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeReg(input logic [1:0] sel, input logic [WW-1:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic clearFlag();
    @(negedge clk);
    flagClr = 1'b1;
    @(negedge clk);
    flagClr = 1'b0;
  endtask

  function automatic logic [NP-1:0] bitOf(input logic b);
    return {{(NP-1){1'b0}}, b};
  endfunction

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #400000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    tick(3);
    // R1 reset state
    check("R1 irqFlag", bitOf(irqFlag), '0);
    check("R1 wakeReq", bitOf(wakeReq), '0);
    check("R1 pullEn", pullEn, '0);
    @(negedge clk); rstN = 1'b1;
    tick(2);

    // R9 register layout: enables pins 0-7, 16, 30; pull-ups all
    writeReg(2'd0, 16'h00FF);
    writeReg(2'd1, 16'h4001);
    writeReg(2'd2, 16'hFFFF);
    writeReg(2'd3, 16'hFFFF);
    pinDir = 31'h0000_F0F0;
    tick(1);
    check("R10 pullEn gated by outputs", pullEn, 31'h7FFF_0F0F);
    pinDir = '0;
    tick(1);
    check("R9 pullEn all words", pullEn, 31'h7FFF_FFFF);

    // R2 rising edge on pin 0
    pinIn[0] = 1'b1;
    tick(2);
    check("R2 not yet set", bitOf(irqFlag), '0);
    tick(1);
    check("R2 rising sets flag", bitOf(irqFlag), 31'd1);
    clearFlag();
    tick(3);
    check("R5 flag cleared, ref reloaded", bitOf(irqFlag), '0);

    // R3 falling edge on pin 0
    pinIn[0] = 1'b0;
    tick(3);
    check("R3 falling sets flag", bitOf(irqFlag), 31'd1);
    // R5 sticky although pin returns to reference level
    pinIn[0] = 1'b1;
    tick(2);
    pinIn[0] = 1'b0;
    tick(4);
    check("R5 flag sticky", bitOf(irqFlag), 31'd1);
    clearFlag();
    tick(3);
    check("R5 cleared", bitOf(irqFlag), '0);

    // R4 disabled pins 8 and 20
    pinIn[8] = 1'b1; pinIn[20] = 1'b1;
    tick(1);
    check("R4 wakeReq quiet", bitOf(wakeReq), '0);
    tick(4);
    check("R4 disabled no flag", bitOf(irqFlag), '0);

    // R11 simultaneous changes
    pinIn[1] = 1'b1; pinIn[2] = 1'b1; pinIn[16] = 1'b1; pinIn[30] = 1'b1;
    tick(4);
    check("R11 multi change flag", bitOf(irqFlag), 31'd1);
    clearFlag();
    tick(4);
    check("R11 single clear", bitOf(irqFlag), '0);

    // R6 clear coincides with a fresh mismatch
    pinIn[3] = 1'b1;
    tick(2);
    flagClr = 1'b1;
    @(negedge clk);
    flagClr = 1'b0;
    tick(3);
    check("R6 clear wins, change absorbed", bitOf(irqFlag), '0);

    // R7 / R8 change while the clock is stopped
    @(negedge clk);
    clkRun = 1'b0;
    #10;
    pinIn[4] = 1'b1;
    #10;
    check("R7 wakeReq without clock", bitOf(wakeReq), 31'd1);
    check("R8 flag waits for clock", bitOf(irqFlag), '0);
    clkRun = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    check("R8 not set after two edges", bitOf(irqFlag), '0);
    @(posedge clk); #1;
    check("R8 set on third edge", bitOf(irqFlag), 31'd1);
    clearFlag();
    tick(3);

    // R9 bit 15 of the high word is ignored; pins 16-30 now disabled
    writeReg(2'd1, 16'h8000);
    pinIn[16] = 1'b0; pinIn[30] = 1'b0;
    tick(4);
    check("R9 hi bit15 ignored", bitOf(irqFlag), '0);
    writeReg(2'd3, 16'h8000);
    tick(1);
    check("R9 pull-up hi word", pullEn, 31'h0000_FFFF);

    tick(3);
    finishRun();
  end

endmodule